// File: doc/BRIEF.md
# Indexed Load-Store Address Unit

This block is the address and writeback stage that serves register-indexed memory operations on a 32-bit big-endian core. An operation arrives with its opcode, the number and value of the base register, the value of the index register, and the number of the destination register (for loads) or the value of the source register (for stores). The block adds base and index to form the effective address. Register 0 counts as the constant zero when it is named as the base. The block then issues one memory access and finishes the register writes for the operation.

The block is built around a two-state machine. In state IDLE the block accepts an operation (transition ISSUE) and captures the effective address and the decoded operation. In state ACCESS it drives a request that stays steady (transition HOLD) until the memory acknowledges it. In the acknowledge cycle (transition DONE) a load writes its aligned, extended result to the destination port. An update form writes the effective address to the base-register port in the same cycle.

Bytes and half-words sit in big-endian lanes of the bus word, chosen by the low address bits. Register 0 as base follows two rules. A load with update skips its base write when the base is register 0 or equals the destination. A store with update still writes register 0.

Top module: `lsx_idx_agu`

## Requirements
- R1: During and after reset, and after a reset that arrives in the middle of an access, `idle` is 1 and `mem_req`, `rd_we` and `ra_we` are 0.
- R2: `mem_addr` equals `index_val` plus `base_val`, or `index_val` alone when `base_num` is 0, modulo 2^32.
- R3: `issue` is taken only in IDLE. `mem_req` rises in the cycle after acceptance. While it waits for `mem_ack`, it holds the address, enables, data and direction unchanged. It falls in the cycle after the acknowledge, and `issue` in ACCESS is ignored.
- R4: The opcode is {store, kind[1:0], update}. The loads are 0000/0001 byte-zero, 0010/0011 half-zero, 0100/0101 half-signed and 0110/0111 word. The stores are 1000/1001 byte, 1010/1011 half and 1110/1111 word. `mem_we` equals the store bit, and `mem_size` is 0 for a byte, 1 for a half-word and 2 for a word.
- R5: `mem_be[i]` enables bus bits 8i+7:8i. A byte at offset k sets only bit 3-k. A half-word at offset 0 gives 1100, at offset 2 it gives 0011, and a word gives 1111.
- R6: A store places the low 8 bits (byte) or low 16 bits (half-word) of `src_val`, or the whole value (word), in the enabled lanes.
- R7: Byte and half-word zero loads return the selected lane data with all higher bits cleared. A word load returns the bus word.
- R8: A half-word signed load copies bit 15 of the loaded half-word into bits 31:16.
- R9: `rd_we` and `ra_we` are raised only in the acknowledge cycle. `rd_we` is raised only for loads, with `rd_num` equal to the captured destination.
- R10: An update form writes the effective address through `ra_num`/`ra_data` in the acknowledge cycle. A non-update form never raises `ra_we`.
- R11: A load with update raises no `ra_we` when the base number is 0 or equals the destination number.
- R12: A store with update and base number 0 still raises `ra_we`, with `ra_num` 0 and the effective address as data.
- R13: `rd_we` and `ra_we` are never both high for the same register number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue | input | 1 | Operation present on the operand inputs |
| op | input | 4 | Operation code |
| base_num | input | 5 | Base register number |
| base_val | input | 32 | Base register value |
| index_val | input | 32 | Index register value |
| dst_num | input | 5 | Destination register number (loads) |
| src_val | input | 32 | Source register value (stores) |
| idle | output | 1 | Machine in IDLE, ready to accept |
| mem_req | output | 1 | Memory request strobe |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Effective byte address |
| mem_size | output | 2 | Access size code |
| mem_be | output | 4 | Lane enables |
| mem_wdata | output | 32 | Lane-placed store data |
| mem_rdata | input | 32 | Returned bus word |
| mem_ack | input | 1 | Memory acknowledge |
| rd_we | output | 1 | Destination write enable |
| rd_num | output | 5 | Destination register number |
| rd_data | output | 32 | Aligned and extended load result |
| ra_we | output | 1 | Base-register update enable |
| ra_num | output | 5 | Base register number for update |
| ra_data | output | 32 | Effective address written back |

## Verification
The bench builds the block with its defaults: a 32-bit bus, which gives four byte lanes, and 5-bit register numbers, which give 32 registers. Four lanes make every byte offset and both half-word positions reachable. With 32 registers the bench can name register 0 as base, name a base equal to the destination, and name distinct registers, so every update-suppression case comes up for every operation. Address wraparound at the 32-bit limit is also reachable at this width.

// File: rtl/lsx_pkg.sv
package lsx_pkg;

    // Operation code: {store, kind[1:0], update}
    typedef enum logic [3:0] {
        OP_LD_B    = 4'b0000,
        OP_LD_B_U  = 4'b0001,
        OP_LD_H    = 4'b0010,
        OP_LD_H_U  = 4'b0011,
        OP_LD_HS   = 4'b0100,
        OP_LD_HS_U = 4'b0101,
        OP_LD_W    = 4'b0110,
        OP_LD_W_U  = 4'b0111,
        OP_ST_B    = 4'b1000,
        OP_ST_B_U  = 4'b1001,
        OP_ST_H    = 4'b1010,
        OP_ST_H_U  = 4'b1011,
        OP_ST_W    = 4'b1110,
        OP_ST_W_U  = 4'b1111
    } lsx_op_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } lsx_size_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_ACCESS = 1'b1
    } lsx_state_e;

    typedef struct packed {
        logic      store;
        logic      update;
        lsx_size_e size;
        logic      sext;
    } lsx_dec_t;

    function automatic lsx_dec_t lsx_decode(input logic [3:0] code);
        lsx_dec_t d;
        d.store  = code[3];
        d.update = code[0];
        d.sext   = 1'b0;
        case (code[2:1])
            2'b00:   d.size = SZ_BYTE;
            2'b01:   d.size = SZ_HALF;
            2'b10: begin
                d.size = SZ_HALF;
                d.sext = ~code[3];
            end
            default: d.size = SZ_WORD;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/lsx_ea_gen.sv
module lsx_ea_gen #(
    parameter int DATA_W = 32,
    parameter int REG_AW = 5
) (
    input  logic [REG_AW-1:0] base_num,
    input  logic [DATA_W-1:0] base_val,
    input  logic [DATA_W-1:0] index_val,
    output logic [DATA_W-1:0] ea
);

    logic              base_is_zero_reg;
    logic [DATA_W-1:0] base_operand;

    // Register 0 as base stands for the constant zero, not its contents
    assign base_is_zero_reg = (base_num == '0);
    assign base_operand     = base_is_zero_reg ? '0 : base_val;
    assign ea               = base_operand + index_val;

endmodule

// File: rtl/lsx_lane_pack.sv
module lsx_lane_pack
    import lsx_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8,
    localparam int OFF_W = $clog2(LANES)
) (
    input  lsx_size_e          size,
    input  logic [OFF_W-1:0]   off,
    input  logic [DATA_W-1:0]  src,
    output logic [LANES-1:0]   be,
    output logic [DATA_W-1:0]  wdata
);

    int byte_lane;
    int half_hi;
    int half_lo;

    // Big-endian: the lowest address maps to the most significant lane
    always_comb begin
        byte_lane = LANES - 1 - int'(off);
        half_hi   = LANES - 1 - int'({off[OFF_W-1:1], 1'b0});
        half_lo   = half_hi - 1;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic       lane_en;
        logic [7:0] lane_d;

        always_comb begin
            lane_en = 1'b0;
            lane_d  = '0;
            unique case (size)
                SZ_BYTE: begin
                    if (g == byte_lane) begin
                        lane_en = 1'b1;
                        lane_d  = src[7:0];
                    end
                end
                SZ_HALF: begin
                    if (g == half_hi) begin
                        lane_en = 1'b1;
                        lane_d  = src[15:8];
                    end else if (g == half_lo) begin
                        lane_en = 1'b1;
                        lane_d  = src[7:0];
                    end
                end
                SZ_WORD: begin
                    lane_en = 1'b1;
                    lane_d  = src[8*g +: 8];
                end
                default: begin
                    lane_en = 1'b0;
                    lane_d  = '0;
                end
            endcase
        end

        assign be[g]          = lane_en;
        assign wdata[8*g +: 8] = lane_d;
    end

endmodule

// File: rtl/lsx_load_align.sv
module lsx_load_align
    import lsx_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8,
    localparam int OFF_W = $clog2(LANES)
) (
    input  lsx_size_e          size,
    input  logic               sext,
    input  logic [OFF_W-1:0]   off,
    input  logic [DATA_W-1:0]  rdata,
    output logic [DATA_W-1:0]  result
);

    int          byte_lane;
    int          half_lo;
    logic [7:0]  sel_byte;
    logic [15:0] sel_half;

    always_comb begin
        byte_lane = LANES - 1 - int'(off);
        half_lo   = LANES - 2 - int'({off[OFF_W-1:1], 1'b0});
        sel_byte  = rdata[8*byte_lane +: 8];
        sel_half  = rdata[8*half_lo +: 16];
    end

    always_comb begin
        unique case (size)
            SZ_BYTE: result = {{(DATA_W-8){1'b0}}, sel_byte};
            SZ_HALF: begin
                if (sext) result = {{(DATA_W-16){sel_half[15]}}, sel_half};
                else      result = {{(DATA_W-16){1'b0}}, sel_half};
            end
            SZ_WORD: result = rdata;
            default: result = '0;
        endcase
    end

endmodule

// File: rtl/lsx_wb_ctrl.sv
module lsx_wb_ctrl #(
    parameter int REG_AW = 5
) (
    input  logic              complete,
    input  logic              is_store,
    input  logic              update,
    input  logic [REG_AW-1:0] base_num,
    input  logic [REG_AW-1:0] dst_num,
    output logic              rd_we,
    output logic              ra_we
);

    logic base_zero;
    logic base_is_dst;

    assign base_zero   = (base_num == '0);
    assign base_is_dst = (base_num == dst_num);

    always_comb begin
        rd_we = complete && !is_store;
        if (is_store) begin
            // Stores keep the update even with register 0 as base
            ra_we = complete && update;
        end else begin
            // Loads drop the update for the two invalid base choices
            ra_we = complete && update && !base_zero && !base_is_dst;
        end
    end

    // R13: the two write ports never aim at one register
    always_comb begin
        if (rd_we && ra_we) begin
            a_r13_port_clash: assert (base_num != dst_num)
                else $error("destination and base writes share a register");
        end
    end

endmodule

// File: rtl/lsx_idx_agu.sv
module lsx_idx_agu
    import lsx_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int REG_AW = 5,
    localparam int LANES = DATA_W / 8,
    localparam int OFF_W = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic [3:0]        op,
    input  logic [REG_AW-1:0] base_num,
    input  logic [DATA_W-1:0] base_val,
    input  logic [DATA_W-1:0] index_val,
    input  logic [REG_AW-1:0] dst_num,
    input  logic [DATA_W-1:0] src_val,
    output logic              idle,
    output logic              mem_req,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_addr,
    output logic [1:0]        mem_size,
    output logic [LANES-1:0]  mem_be,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic              rd_we,
    output logic [REG_AW-1:0] rd_num,
    output logic [DATA_W-1:0] rd_data,
    output logic              ra_we,
    output logic [REG_AW-1:0] ra_num,
    output logic [DATA_W-1:0] ra_data
);

    lsx_state_e        state_q, state_d;
    lsx_dec_t          dec_q;
    logic [DATA_W-1:0] ea_next, ea_q;
    logic [REG_AW-1:0] base_num_q, dst_num_q;
    logic [DATA_W-1:0] src_q;
    logic              accept;
    logic              complete;
    logic [LANES-1:0]  be_w;
    logic [DATA_W-1:0] wdata_w;
    logic [DATA_W-1:0] load_w;

    lsx_ea_gen #(.DATA_W(DATA_W), .REG_AW(REG_AW)) u_ea_gen (
        .base_num  (base_num),
        .base_val  (base_val),
        .index_val (index_val),
        .ea        (ea_next)
    );

    assign accept = issue && (state_q == ST_IDLE);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Operand capture on ISSUE
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_q      <= '0;
            ea_q       <= '0;
            base_num_q <= '0;
            dst_num_q  <= '0;
            src_q      <= '0;
        end else if (accept) begin
            dec_q      <= lsx_decode(op);
            ea_q       <= ea_next;
            base_num_q <= base_num;
            dst_num_q  <= dst_num;
            src_q      <= src_val;
        end
    end

    // Next state: ISSUE, HOLD, DONE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (issue)   state_d = ST_ACCESS;
            ST_ACCESS: if (mem_ack) state_d = ST_IDLE;
            default:                state_d = ST_IDLE;
        endcase
    end

    // State outputs
    always_comb begin
        idle     = 1'b0;
        mem_req  = 1'b0;
        complete = 1'b0;
        unique case (state_q)
            ST_IDLE:   idle = 1'b1;
            ST_ACCESS: begin
                mem_req  = 1'b1;
                complete = mem_ack;
            end
            default:   idle = 1'b1;
        endcase
    end

    lsx_lane_pack #(.DATA_W(DATA_W)) u_lane_pack (
        .size  (dec_q.size),
        .off   (ea_q[OFF_W-1:0]),
        .src   (src_q),
        .be    (be_w),
        .wdata (wdata_w)
    );

    lsx_load_align #(.DATA_W(DATA_W)) u_load_align (
        .size   (dec_q.size),
        .sext   (dec_q.sext),
        .off    (ea_q[OFF_W-1:0]),
        .rdata  (mem_rdata),
        .result (load_w)
    );

    lsx_wb_ctrl #(.REG_AW(REG_AW)) u_wb_ctrl (
        .complete (complete),
        .is_store (dec_q.store),
        .update   (dec_q.update),
        .base_num (base_num_q),
        .dst_num  (dst_num_q),
        .rd_we    (rd_we),
        .ra_we    (ra_we)
    );

    assign mem_we    = mem_req && dec_q.store;
    assign mem_addr  = ea_q;
    assign mem_size  = dec_q.size;
    assign mem_be    = mem_req ? be_w : '0;
    assign mem_wdata = mem_we ? wdata_w : '0;
    assign rd_num    = dst_num_q;
    assign rd_data   = load_w;
    assign ra_num    = base_num_q;
    assign ra_data   = ea_q;

    // R3: request stays steady while it waits
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_be)
                                   && $stable(mem_wdata) && $stable(mem_we)));

    // R3: request drops after acknowledge
    a_r3_release: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack) |=> !mem_req);

    // R9: register writes only in an acknowledge cycle
    a_r9_wr_in_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_we || ra_we) |-> (mem_req && mem_ack));

    // R9: stores never write the destination port
    a_r9_store_no_rd: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !rd_we);

    // R1: no request while ready
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> (!mem_req && !rd_we && !ra_we));

    // R5: an access enables at least one lane
    a_r5_lane_used: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> ($countones(mem_be) >= 1));

endmodule

// File: tb/lsx_idx_agu_bench.sv
module lsx_idx_agu_bench;
    import lsx_pkg::*;

    localparam int DW  = 32;
    localparam int RAW = 5;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           issue;
    logic [3:0]     op;
    logic [RAW-1:0] base_num, dst_num;
    logic [DW-1:0]  base_val, index_val, src_val;
    logic           idle, mem_req, mem_we, mem_ack;
    logic [DW-1:0]  mem_addr, mem_wdata, mem_rdata;
    logic [1:0]     mem_size;
    logic [3:0]     mem_be;
    logic           rd_we, ra_we;
    logic [RAW-1:0] rd_num, ra_num;
    logic [DW-1:0]  rd_data, ra_data;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] mem [16];

    // 4 ns period
    always #2 clk = ~clk;

    lsx_idx_agu #(.DATA_W(DW), .REG_AW(RAW)) u_lsx_idx_agu (
        .clk(clk), .rst_n(rst_n), .issue(issue), .op(op),
        .base_num(base_num), .base_val(base_val), .index_val(index_val),
        .dst_num(dst_num), .src_val(src_val), .idle(idle),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_size(mem_size), .mem_be(mem_be), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .rd_we(rd_we), .rd_num(rd_num), .rd_data(rd_data),
        .ra_we(ra_we), .ra_num(ra_num), .ra_data(ra_data)
    );

    localparam lsx_op_e OPS [14] = '{
        OP_LD_B, OP_LD_B_U, OP_LD_H, OP_LD_H_U, OP_LD_HS, OP_LD_HS_U,
        OP_LD_W, OP_LD_W_U, OP_ST_B, OP_ST_B_U, OP_ST_H, OP_ST_H_U,
        OP_ST_W, OP_ST_W_U
    };

    task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    function automatic logic [3:0] be_for(input logic [3:0] code, input int off);
        case (code[2:1])
            2'b00:   return 4'b1000 >> off;
            2'b11:   return 4'b1111;
            default: return (off >= 2) ? 4'b0011 : 4'b1100;
        endcase
    endfunction

    function automatic logic [1:0] size_for(input logic [3:0] code);
        case (code[2:1])
            2'b00:   return 2'd0;
            2'b11:   return 2'd2;
            default: return 2'd1;
        endcase
    endfunction

    function automatic logic [31:0] ld_for(input logic [3:0] code, input int off,
                                           input logic [31:0] word);
        logic [7:0]  b;
        logic [15:0] h;
        b = word[31-8*off -: 8];
        h = (off >= 2) ? word[15:0] : word[31:16];
        case (code[2:1])
            2'b00:   return {24'h0, b};
            2'b01:   return {16'h0, h};
            2'b10:   return {{16{h[15]}}, h};
            default: return word;
        endcase
    endfunction

    task automatic run_one(input logic [3:0] code, input logic [4:0] ra,
                           input logic [4:0] rd, input logic [31:0] rav,
                           input logic [31:0] rbv, input logic [31:0] srcv);
        logic [31:0] ea, pat, mask, ld_exp;
        logic [3:0]  be;
        int          w, off;
        bit          st, upd, ra_exp;
        string       wtag;
        ea   = ((ra == 0) ? 32'h0 : rav) + rbv;
        off  = int'(ea[1:0]);
        w    = int'(ea[5:2]);
        st   = code[3];
        upd  = code[0];
        be   = be_for(code, off);
        mask = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
        case (code[2:1])
            2'b00:   pat = {4{srcv[7:0]}};
            2'b11:   pat = srcv;
            default: pat = {2{srcv[15:0]}};
        endcase

        @(negedge clk);
        issue = 1'b1; op = code; base_num = ra; dst_num = rd;
        base_val = rav; index_val = rbv; src_val = srcv;
        @(negedge clk);
        issue = 1'b0;
        chk(mem_req == 1'b1, "R3 request raised", 32'(mem_req), 32'h1);
        chk(mem_addr == ea, "R2 effective address", mem_addr, ea);
        chk(mem_we == st, "R4 direction", 32'(mem_we), 32'(st));
        chk(mem_size == size_for(code), "R4 size code", 32'(mem_size), 32'(size_for(code)));
        chk(mem_be == be, "R5 lane enables", 32'(mem_be), 32'(be));
        if (st) chk((mem_wdata & mask) == (pat & mask), "R6 store lanes",
                    mem_wdata & mask, pat & mask);
        chk(!rd_we && !ra_we, "R9 no write before ack", {rd_we, ra_we}, 32'h0);

        @(negedge clk);
        chk(mem_req && mem_addr == ea && mem_be == be, "R3 hold while waiting",
            mem_addr, ea);

        mem_ack   = 1'b1;
        mem_rdata = st ? 32'hDEAD_BEEF : mem[w];
        #1;
        if (!st) begin
            ld_exp = ld_for(code, off, mem[w]);
            chk(rd_we == 1'b1 && rd_num == rd, "R9 load destination write",
                {rd_we, 26'h0, rd_num}, {1'b1, 26'h0, rd});
            if (code[2:1] == 2'b10) chk(rd_data == ld_exp, "R8 signed half", rd_data, ld_exp);
            else                    chk(rd_data == ld_exp, "R7 zero load", rd_data, ld_exp);
        end else begin
            chk(rd_we == 1'b0, "R9 store has no destination write", 32'(rd_we), 32'h0);
        end
        ra_exp = upd && (st || (ra != 0 && ra != rd));
        if (st && upd && ra == 0)             wtag = "R12 store update to r0";
        else if (!st && upd && (ra == 0 || ra == rd)) wtag = "R11 load update suppressed";
        else                                  wtag = "R10 base update";
        chk(ra_we == ra_exp, wtag, 32'(ra_we), 32'(ra_exp));
        if (ra_exp) chk(ra_num == ra && ra_data == ea, "R10 update value", ra_data, ea);
        chk(!(rd_we && ra_we && rd_num == ra_num), "R13 write ports distinct",
            32'(ra_num), 32'(rd_num));
        if (st) begin
            for (int l = 0; l < 4; l++) if (be[l]) mem[w][8*l +: 8] = pat[8*l +: 8];
        end

        @(negedge clk);
        mem_ack = 1'b0;
        chk(idle && !mem_req, "R3 back to idle", {idle, mem_req}, 32'h2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R3 watchdog: actual 200000 cycles expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int iter;
        logic [4:0] ra, rd;
        rst_n = 1'b0; issue = 1'b0; op = '0; base_num = '0; dst_num = '0;
        base_val = '0; index_val = '0; src_val = '0; mem_ack = 1'b0; mem_rdata = '0;
        for (int i = 0; i < 16; i++) mem[i] = 32'h8A5C_3E71 ^ (32'(i) * 32'h0107_0B13);
        repeat (3) @(negedge clk);
        chk(idle && !mem_req && !rd_we && !ra_we, "R1 reset state",
            {idle, mem_req, rd_we, ra_we}, 32'h8);
        rst_n = 1'b1;
        @(negedge clk);
        chk(idle && !mem_req, "R1 idle after reset", {idle, mem_req}, 32'h2);

        // Table walk: every operation, every legal offset, three register cases
        iter = 0;
        for (int oi = 0; oi < 14; oi++) begin
            for (int off = 0; off < 4; off++) begin
                if (OPS[oi][2:1] == 2'b11 && off != 0) continue;
                if (OPS[oi][2:1] != 2'b00 && off[0]) continue;
                for (int rc = 0; rc < 3; rc++) begin
                    case (rc)
                        0:       begin ra = 5'd0;  rd = 5'd7; end
                        1:       begin ra = 5'd5;  rd = 5'd5; end
                        default: begin ra = 5'd12; rd = 5'd9; end
                    endcase
                    run_one(OPS[oi], ra, rd, 32'h0000_1000 + 32'(rc) * 32'h40,
                            32'(off) + 32'((iter * 4) % 64),
                            32'hC3D4_E5F6 + 32'(iter) * 32'h0103_0507);
                    iter++;
                end
            end
        end

        // R2: address wraps at the 32-bit limit
        run_one(OP_LD_HS, 5'd3, 5'd4, 32'hFFFF_FFF8, 32'h0000_000A, 32'h0);
        // R12: store update through r0 with a large base value present
        run_one(OP_ST_W_U, 5'd0, 5'd0, 32'hFFFF_0000, 32'h0000_0014, 32'h1357_9BDF);

        // R3: issue while busy is ignored
        @(negedge clk);
        issue = 1'b1; op = OP_LD_W; base_num = 5'd2; dst_num = 5'd6;
        base_val = 32'h0000_0020; index_val = 32'h0000_0004;
        @(negedge clk);
        op = OP_ST_B_U; base_num = 5'd8; dst_num = 5'd1;
        base_val = 32'h0000_0300; index_val = 32'h0000_0001;
        @(negedge clk);
        issue = 1'b0;
        chk(mem_addr == 32'h24 && !mem_we, "R3 busy issue ignored", mem_addr, 32'h24);
        mem_ack = 1'b1; mem_rdata = 32'h0BAD_F00D;
        #1;
        chk(rd_we && rd_num == 5'd6 && !ra_we, "R3 first operation completes",
            32'(rd_num), 32'd6);
        @(negedge clk);
        mem_ack = 1'b0;
        @(negedge clk);
        chk(idle && !mem_req, "R3 second issue not latched", {idle, mem_req}, 32'h2);

        // R1: reset in the middle of an access
        @(negedge clk);
        issue = 1'b1; op = OP_ST_H_U; base_num = 5'd4; base_val = 32'h40; index_val = 32'h2;
        @(negedge clk);
        issue = 1'b0;
        chk(mem_req == 1'b1, "R3 request before reset", 32'(mem_req), 32'h1);
        rst_n = 1'b0;
        @(negedge clk);
        chk(idle && !mem_req && !rd_we && !ra_we, "R1 reset aborts access",
            {idle, mem_req, rd_we, ra_we}, 32'h8);
        rst_n = 1'b1;
        @(negedge clk);
        chk(idle && !mem_req, "R1 idle after abort", {idle, mem_req}, 32'h2);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule